// File: doc/BRIEF.md
# Indirect IO configuration port translator

This block sits between a processor-side IO bus and a configuration request generator. It gives software a two-port window into configuration space. A full dword write to an address port at IO 0CF8h stores a target selector. The selector holds an enable flag and the bus, device, function and dword number. An access to the data window at IO 0CFCh–0CFFh then becomes a configuration read or write for that target, but only while the enable flag is set. With the flag clear, the data window behaves like any other IO address and the access is forwarded unchanged on a pass-through IO request interface.

Each IO access is a request held until a one-cycle acknowledge. Data is lane-aligned to the dword, so byte N of the dword travels on bits 8N+7:8N. The translator allows one downstream request at a time and stalls the IO access until the target completes. A read whose target reports absence returns all ones.

Top module: `cfg_io_xlate`

## Requirements
- R1: After a synchronous reset the selector register is zero and io_ack, cfg_req and pt_req are low; a dword read of 0CF8h then returns 0.
- R2: A write of size dword (io_size=2) at exactly 0CF8h stores io_wdata with bits 1:0 forced to zero, and a dword read of 0CF8h returns the stored value; neither access drives cfg_req or pt_req and both are acknowledged one cycle after acceptance.
- R3: A byte or word access (io_size 0 or 1) anywhere in 0CF8h–0CFBh, or a misaligned dword there, is forwarded as a pass-through request, and the selector keeps its value.
- R4: With selector bit 31 set, an access in 0CFCh–0CFFh issues cfg_req with bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword number = bits 7:2 of the selector.
- R5: cfg_be is the size mask (byte 0001b, word 0011b, dword 1111b) shifted left by io_addr[1:0], truncated to 4 bits.
- R6: With selector bit 31 clear, an access in 0CFCh–0CFFh is forwarded unchanged on the pass-through interface and no configuration request is issued.
- R7: A configuration read completed with cfg_found low returns FFFFFFFFh on io_rdata.
- R8: Configuration writes carry io_wdata unchanged on cfg_wdata and return zero on io_rdata; configuration reads that find the target return cfg_rdata.
- R9: At most one of cfg_req and pt_req is high, the request and its fields hold steady until its done pulse, and io_ack rises for exactly one cycle in the cycle after that done pulse.
- R10: Accesses to any other IO address are forwarded with address, size, direction and write data unchanged, and pass-through reads return pt_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | IO access request, held until io_ack |
| io_we | input | 1 | 1 = IO write |
| io_addr | input | 16 | IO byte address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Lane-aligned write data |
| io_ack | output | 1 | One-cycle completion of the IO access |
| io_rdata | output | 32 | Lane-aligned read data, valid with io_ack |
| cfg_req | output | 1 | Configuration request, held until cfg_done |
| cfg_we | output | 1 | 1 = configuration write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_dw | output | 6 | Target dword number |
| cfg_be | output | 4 | Byte enables within the dword |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_done | input | 1 | Configuration completion pulse |
| cfg_found | input | 1 | Target exists, with cfg_done |
| cfg_rdata | input | 32 | Configuration read data, with cfg_done |
| pt_req | output | 1 | Pass-through IO request, held until pt_done |
| pt_we | output | 1 | Pass-through direction |
| pt_addr | output | 16 | Pass-through address |
| pt_size | output | 2 | Pass-through size |
| pt_wdata | output | 32 | Pass-through write data |
| pt_done | input | 1 | Pass-through completion pulse |
| pt_rdata | input | 32 | Pass-through read data, with pt_done |

## Verification
Two functions can land on the same clock edge: a downstream completion and the issue of its request. The bench's responder raises cfg_done or pt_done in the very first cycle the request is visible for some accesses, and waits up to three cycles for others. For each access the bench counts the cycles from request to io_ack against two plus that latency and compares the captured request fields. A selector write is also followed at once by a data-window access, so the decode must already see the new enable flag and target.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  localparam int DW_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } io_size_e;

  typedef enum logic [1:0] {
    CLS_SEL_WR = 2'd0,
    CLS_SEL_RD = 2'd1,
    CLS_CFG    = 2'd2,
    CLS_PASS   = 2'd3
  } acc_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CFG  = 2'd1,
    ST_PASS = 2'd2,
    ST_GAP  = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] dw;
  } cfg_tgt_t;

  function automatic logic [3:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 4'b0001;
      SZ_WORD: size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/cfgx_sel_reg.sv
module cfgx_sel_reg
  import cfgx_pkg::*;
#(
  parameter int EN_BIT   = 31,
  parameter int BUS_LSB  = 16,
  parameter int DEV_LSB  = 11,
  parameter int FUNC_LSB = 8,
  parameter int DW_LSB   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW_W-1:0] wr_data,
  output logic [DW_W-1:0] sel_q,
  output logic            sel_en,
  output cfg_tgt_t        sel_tgt
);

  localparam int BUS_W  = $bits(sel_tgt.bus);
  localparam int DEV_W  = $bits(sel_tgt.dev);
  localparam int FUNC_W = $bits(sel_tgt.func);
  localparam int IDX_W  = $bits(sel_tgt.dw);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
    end else if (wr_en) begin
      sel_q <= {wr_data[DW_W-1:DW_LSB], {DW_LSB{1'b0}}};
    end
  end

  always_comb begin
    sel_en       = sel_q[EN_BIT];
    sel_tgt.bus  = sel_q[BUS_LSB  +: BUS_W];
    sel_tgt.dev  = sel_q[DEV_LSB  +: DEV_W];
    sel_tgt.func = sel_q[FUNC_LSB +: FUNC_W];
    sel_tgt.dw   = sel_q[DW_LSB   +: IDX_W];
  end

endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SEL_PORT  = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic              en,
  output acc_cls_e          cls,
  output logic [3:0]        be
);

  localparam int DWA_W = ADDR_W - 2;

  logic       hit_sel;
  logic       hit_data;
  logic       full_dw;
  logic [7:0] be_wide;

  always_comb begin
    hit_sel  = (addr[ADDR_W-1:2] == SEL_PORT[ADDR_W-1:2]);
    hit_data = (addr[ADDR_W-1:2] == DATA_PORT[ADDR_W-1:2]);
    full_dw  = (size == SZ_DWORD) && (addr[1:0] == 2'b00);
    be_wide  = {4'b0000, size_mask(size)} << addr[1:0];
    be       = be_wide[3:0];

    if (hit_sel && full_dw) begin
      cls = we ? CLS_SEL_WR : CLS_SEL_RD;
    end else if (hit_data && en) begin
      cls = CLS_CFG;
    end else begin
      cls = CLS_PASS;
    end
  end

  logic [DWA_W-1:0] unused_dwa;
  assign unused_dwa = '0;

endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
  import cfgx_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [DW_W-1:0]   io_wdata,
  output logic              io_ack,
  output logic [DW_W-1:0]   io_rdata,
  input  acc_cls_e          cls,
  input  logic [3:0]        be,
  input  logic [DW_W-1:0]   sel_q,
  input  cfg_tgt_t          sel_tgt,
  output logic              sel_wr,
  output logic              cfg_req,
  output logic              cfg_we,
  output cfg_tgt_t          cfg_tgt,
  output logic [3:0]        cfg_be,
  output logic [DW_W-1:0]   cfg_wdata,
  input  logic              cfg_done,
  input  logic              cfg_found,
  input  logic [DW_W-1:0]   cfg_rdata,
  output logic              pt_req,
  output logic              pt_we,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [1:0]        pt_size,
  output logic [DW_W-1:0]   pt_wdata,
  input  logic              pt_done,
  input  logic [DW_W-1:0]   pt_rdata
);

  seq_st_e st;
  logic    take;

  assign take   = (st == ST_IDLE) && io_req;
  assign sel_wr = take && (cls == CLS_SEL_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      cfg_req   <= 1'b0;
      cfg_we    <= 1'b0;
      cfg_tgt   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
      pt_req    <= 1'b0;
      pt_we     <= 1'b0;
      pt_addr   <= '0;
      pt_size   <= '0;
      pt_wdata  <= '0;
    end else begin
      io_ack <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (take) begin
            case (cls)
              CLS_SEL_WR: begin
                io_ack   <= 1'b1;
                io_rdata <= '0;
                st       <= ST_GAP;
              end
              CLS_SEL_RD: begin
                io_ack   <= 1'b1;
                io_rdata <= sel_q;
                st       <= ST_GAP;
              end
              CLS_CFG: begin
                cfg_req   <= 1'b1;
                cfg_we    <= io_we;
                cfg_tgt   <= sel_tgt;
                cfg_be    <= be;
                cfg_wdata <= io_wdata;
                st        <= ST_CFG;
              end
              default: begin
                pt_req   <= 1'b1;
                pt_we    <= io_we;
                pt_addr  <= io_addr;
                pt_size  <= io_size;
                pt_wdata <= io_wdata;
                st       <= ST_PASS;
              end
            endcase
          end
        end
        ST_CFG: begin
          if (cfg_done) begin
            cfg_req <= 1'b0;
            io_ack  <= 1'b1;
            if (cfg_we)         io_rdata <= '0;
            else if (cfg_found) io_rdata <= cfg_rdata;
            else                io_rdata <= '1;
            st <= ST_GAP;
          end
        end
        ST_PASS: begin
          if (pt_done) begin
            pt_req   <= 1'b0;
            io_ack   <= 1'b1;
            io_rdata <= pt_we ? '0 : pt_rdata;
            st       <= ST_GAP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_io_xlate.sv
module cfg_io_xlate
  import cfgx_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] SEL_PORT  = 16'h0CF8,
  parameter logic [ADDR_W-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_we,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [1:0]        io_size,
  input  logic [31:0]       io_wdata,
  output logic              io_ack,
  output logic [31:0]       io_rdata,
  output logic              cfg_req,
  output logic              cfg_we,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_func,
  output logic [5:0]        cfg_dw,
  output logic [3:0]        cfg_be,
  output logic [31:0]       cfg_wdata,
  input  logic              cfg_done,
  input  logic              cfg_found,
  input  logic [31:0]       cfg_rdata,
  output logic              pt_req,
  output logic              pt_we,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [1:0]        pt_size,
  output logic [31:0]       pt_wdata,
  input  logic              pt_done,
  input  logic [31:0]       pt_rdata
);

  logic [DW_W-1:0] sel_q;
  logic            sel_en;
  logic            sel_wr;
  cfg_tgt_t        sel_tgt;
  cfg_tgt_t        cfg_tgt;
  acc_cls_e        cls;
  logic [3:0]      be;

  cfgx_sel_reg i_sel (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sel_wr),
    .wr_data (io_wdata),
    .sel_q   (sel_q),
    .sel_en  (sel_en),
    .sel_tgt (sel_tgt)
  );

  cfgx_decode #(
    .ADDR_W    (ADDR_W),
    .SEL_PORT  (SEL_PORT),
    .DATA_PORT (DATA_PORT)
  ) i_dec (
    .addr (io_addr),
    .we   (io_we),
    .size (io_size),
    .en   (sel_en),
    .cls  (cls),
    .be   (be)
  );

  cfgx_seq #(.ADDR_W(ADDR_W)) i_seq (
    .clk       (clk),
    .rst       (rst),
    .io_req    (io_req),
    .io_we     (io_we),
    .io_addr   (io_addr),
    .io_size   (io_size),
    .io_wdata  (io_wdata),
    .io_ack    (io_ack),
    .io_rdata  (io_rdata),
    .cls       (cls),
    .be        (be),
    .sel_q     (sel_q),
    .sel_tgt   (sel_tgt),
    .sel_wr    (sel_wr),
    .cfg_req   (cfg_req),
    .cfg_we    (cfg_we),
    .cfg_tgt   (cfg_tgt),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_done  (cfg_done),
    .cfg_found (cfg_found),
    .cfg_rdata (cfg_rdata),
    .pt_req    (pt_req),
    .pt_we     (pt_we),
    .pt_addr   (pt_addr),
    .pt_size   (pt_size),
    .pt_wdata  (pt_wdata),
    .pt_done   (pt_done),
    .pt_rdata  (pt_rdata)
  );

  assign cfg_bus  = cfg_tgt.bus;
  assign cfg_dev  = cfg_tgt.dev;
  assign cfg_func = cfg_tgt.func;
  assign cfg_dw   = cfg_tgt.dw;

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] SEL_PORT = 16'h0CF8
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic              io_we,
  input logic [ADDR_W-1:0] io_addr,
  input logic [1:0]        io_size,
  input logic              io_ack,
  input logic              cfg_req,
  input logic              cfg_done,
  input logic [7:0]        cfg_bus,
  input logic [4:0]        cfg_dev,
  input logic [2:0]        cfg_func,
  input logic [5:0]        cfg_dw,
  input logic [3:0]        cfg_be,
  input logic              pt_req,
  input logic [31:0]       sel_q
);

  // R1: outputs are quiet right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cfg_req && !pt_req && !io_ack));

  // R2 / R3: selector changes only after a full dword write at its port
  a_r3_sel_only_full_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> $past(io_req && io_we && io_size == 2'd2 && io_addr == SEL_PORT));

  // R2: stored selector never has bits 1:0 set
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    sel_q[1:0] == 2'b00);

  // R4: a configuration request starts only while enabled
  a_r4_cfg_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req) |-> sel_q[31]);

  // R5: a configuration request always enables at least one byte
  a_r5_be_nonzero: assert property (@(posedge clk) disable iff (rst)
    cfg_req |-> (cfg_be != 4'b0000));

  // R9: one request outstanding
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    !(cfg_req && pt_req));

  // R9: request and its fields hold until completion
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && !cfg_done) |=> (cfg_req && $stable(cfg_bus) && $stable(cfg_dev)
                                && $stable(cfg_func) && $stable(cfg_dw) && $stable(cfg_be)));

  // R9: completion leads to a single acknowledge cycle
  a_r9_ack_after_done: assert property (@(posedge clk) disable iff (rst)
    (cfg_req && cfg_done) |=> (io_ack && !cfg_req));

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    io_ack |=> !io_ack);

endmodule

bind cfg_io_xlate cfgx_chk #(.ADDR_W(ADDR_W), .SEL_PORT(SEL_PORT)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .io_req   (io_req),
  .io_we    (io_we),
  .io_addr  (io_addr),
  .io_size  (io_size),
  .io_ack   (io_ack),
  .cfg_req  (cfg_req),
  .cfg_done (cfg_done),
  .cfg_bus  (cfg_bus),
  .cfg_dev  (cfg_dev),
  .cfg_func (cfg_func),
  .cfg_dw   (cfg_dw),
  .cfg_be   (cfg_be),
  .pt_req   (pt_req),
  .sel_q    (sel_q)
);

// File: tb/test_cfg_io_xlate.sv
`timescale 1ns/1ps
module test_cfg_io_xlate;

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        fnd;
    logic [31:0] resp;
    logic [1:0]  path;   // 0 selector, 1 config, 2 pass-through
    logic [3:0]  be;
    logic [31:0] exp;
    logic [1:0]  lat;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd2, 16'h0CF8, 32'h0,        1'b1, 32'h0,        2'd0, 4'h0, 32'h0,        2'd0},
    '{1'b1, 2'd2, 16'h0CF8, 32'h80040000, 1'b1, 32'h0,        2'd0, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd2, 16'h0CF8, 32'h0,        1'b1, 32'h0,        2'd0, 4'h0, 32'h80040000, 2'd0},
    '{1'b0, 2'd1, 16'h0CFC, 32'h0,        1'b1, 32'h1234ABCD, 2'd1, 4'h3, 32'h1234ABCD, 2'd0},
    '{1'b1, 2'd2, 16'h0CF8, 32'h8012FB7F, 1'b1, 32'h0,        2'd0, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd2, 16'h0CF8, 32'h0,        1'b1, 32'h0,        2'd0, 4'h0, 32'h8012FB7C, 2'd0},
    '{1'b1, 2'd0, 16'h0CFF, 32'h55000000, 1'b1, 32'h0,        2'd1, 4'h8, 32'h0,        2'd3},
    '{1'b0, 2'd1, 16'h0CFE, 32'h0,        1'b0, 32'h0BAD0BAD, 2'd1, 4'hC, 32'hFFFFFFFF, 2'd1},
    '{1'b1, 2'd1, 16'h0CF8, 32'h00001111, 1'b1, 32'h0,        2'd2, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd0, 16'h0CFB, 32'h0,        1'b1, 32'hAA000000, 2'd2, 4'h0, 32'hAA000000, 2'd2},
    '{1'b0, 2'd2, 16'h0CF8, 32'h0,        1'b1, 32'h0,        2'd0, 4'h0, 32'h8012FB7C, 2'd0},
    '{1'b1, 2'd2, 16'h0CF8, 32'h00000100, 1'b1, 32'h0,        2'd0, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd2, 16'h0CFC, 32'h0,        1'b1, 32'h00000077, 2'd2, 4'h0, 32'h00000077, 2'd1},
    '{1'b1, 2'd2, 16'h0080, 32'hDEADBEEF, 1'b1, 32'h0,        2'd2, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd0, 16'h03F8, 32'h0,        1'b1, 32'h0000005A, 2'd2, 4'h0, 32'h0000005A, 2'd3},
    '{1'b1, 2'd2, 16'h0CF8, 32'h80FFFFFC, 1'b1, 32'h0,        2'd0, 4'h0, 32'h0,        2'd0},
    '{1'b0, 2'd2, 16'h0CFC, 32'h0,        1'b1, 32'hCAFEF00D, 2'd1, 4'hF, 32'hCAFEF00D, 2'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_ack;
  logic [31:0] io_rdata;
  logic        cfg_req, cfg_we;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_dw;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_done = 1'b0, cfg_found = 1'b0;
  logic [31:0] cfg_rdata = '0;
  logic        pt_req, pt_we;
  logic [15:0] pt_addr;
  logic [1:0]  pt_size;
  logic [31:0] pt_wdata;
  logic        pt_done = 1'b0;
  logic [31:0] pt_rdata = '0;

  always #2 clk = ~clk;

  cfg_io_xlate i_cfg_io_xlate (.*);

  int n_chk = 0, n_bad = 0;
  int lat_cur = 0, cnt_c = 0, cnt_p = 0;
  int seen_c = 0, seen_p = 0;
  logic        fnd_cur = 1'b1;
  logic [31:0] resp_cur = '0;
  logic        c_we;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_dw;
  logic [3:0]  c_be;
  logic [31:0] c_wd;
  logic        p_we;
  logic [15:0] p_addr;
  logic [1:0]  p_sz;
  logic [31:0] p_wd;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // downstream responders
  always @(negedge clk) begin
    if (cfg_done) begin
      cfg_done = 1'b0; cnt_c = 0;
    end else if (cfg_req) begin
      if (cnt_c == lat_cur) begin
        cfg_done = 1'b1; cfg_found = fnd_cur; cfg_rdata = resp_cur; seen_c++;
        c_we = cfg_we; c_bus = cfg_bus; c_dev = cfg_dev; c_func = cfg_func;
        c_dw = cfg_dw; c_be = cfg_be; c_wd = cfg_wdata;
      end else cnt_c++;
    end
    if (pt_done) begin
      pt_done = 1'b0; cnt_p = 0;
    end else if (pt_req) begin
      if (cnt_p == lat_cur) begin
        pt_done = 1'b1; pt_rdata = resp_cur; seen_p++;
        p_we = pt_we; p_addr = pt_addr; p_sz = pt_size; p_wd = pt_wdata;
      end else cnt_p++;
    end
  end

  logic [31:0] model_sel = '0;

  task automatic run_vec(input vec_t v);
    int cyc;
    lat_cur = v.lat; fnd_cur = v.fnd; resp_cur = v.resp;
    seen_c = 0; seen_p = 0;
    io_we = v.we; io_size = v.sz; io_addr = v.addr; io_wdata = v.wd; io_req = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk); cyc++;
    end while (!io_ack && cyc < 100);
    io_req = 1'b0;
    chk(io_ack, "R9", "ack seen", {31'b0, io_ack}, 32'd1);
    chk(cyc == ((v.path == 2'd0) ? 1 : 2 + int'(v.lat)), "R9", "ack cycle", cyc,
        (v.path == 2'd0) ? 1 : 2 + v.lat);
    chk(io_rdata == v.exp, "R2 R7 R8 R10", "read data", io_rdata, v.exp);
    case (v.path)
      2'd0: begin
        chk(seen_c == 0 && seen_p == 0, "R2", "no downstream", seen_c + seen_p, 0);
        if (v.we) model_sel = {v.wd[31:2], 2'b00};
      end
      2'd1: begin
        chk(seen_c == 1 && seen_p == 0, "R4", "config issued", seen_c, 1);
        chk({c_bus, c_dev, c_func, c_dw} ==
            {model_sel[23:16], model_sel[15:11], model_sel[10:8], model_sel[7:2]},
            "R4", "target fields", {10'b0, c_bus, c_dev, c_func, c_dw},
            {10'b0, model_sel[23:16], model_sel[15:11], model_sel[10:8], model_sel[7:2]});
        chk(c_be == v.be, "R5", "byte enables", c_be, v.be);
        chk(c_we == v.we && (!v.we || c_wd == v.wd), "R8", "write data", c_wd, v.wd);
      end
      default: begin
        chk(seen_p == 1 && seen_c == 0, "R3 R6 R10", "pass issued", seen_p, 1);
        chk(p_addr == v.addr && p_sz == v.sz && p_we == v.we, "R10", "pass addr",
            {p_we, 13'b0, p_sz, p_addr}, {v.we, 13'b0, v.sz, v.addr});
        chk(!v.we || p_wd == v.wd, "R10", "pass wdata", p_wd, v.wd);
      end
    endcase
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!io_ack && !cfg_req && !pt_req, "R1", "idle after reset",
        {29'b0, io_ack, cfg_req, pt_req}, 32'd0);
    for (int i = 0; i < NV; i++) run_vec(TBL[i]);
    // reset returns the selector to zero
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!io_ack && !cfg_req && !pt_req, "R1", "idle after second reset",
        {29'b0, io_ack, cfg_req, pt_req}, 32'd0);
    model_sel = '0;
    run_vec('{1'b0, 2'd2, 16'h0CF8, 32'h0, 1'b1, 32'h0, 2'd0, 4'h0, 32'h0, 2'd0});
    // selector write then immediate data access in the next idle slot (R4)
    run_vec('{1'b1, 2'd2, 16'h0CF8, 32'h8A5D3A24, 1'b1, 32'h0, 2'd0, 4'h0, 32'h0, 2'd0});
    run_vec('{1'b1, 2'd1, 16'h0CFD, 32'h00BEEF00, 1'b1, 32'h0, 2'd1, 4'h6, 32'h0, 2'd0});
    // misaligned dword at selector port passes through, selector kept (R3)
    run_vec('{1'b1, 2'd2, 16'h0CF9, 32'h11111111, 1'b1, 32'h0, 2'd2, 4'h0, 32'h0, 2'd1});
    run_vec('{1'b0, 2'd2, 16'h0CF8, 32'h0, 1'b1, 32'h0, 2'd0, 4'h0, 32'h8A5D3A24, 2'd0});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule